// File: doc/BRIEF.md
# AXI4 Read-Only Memory Subordinate

This block answers AXI4 read requests from a fixed internal word array. A manager places one request on the read address channel: a start address, a beat count minus one, and a transaction identifier. After a fixed access delay the block streams the requested words back on the read data channel, one beat per accepted handshake. Every beat carries its own response code. The final beat is flagged with RLAST.

Bursts are incrementing and use the full bus width. Only one read is in flight at a time. A beat whose byte address falls past the end of the array is answered with a decode error and zero data. Every in-range beat of the same burst still returns normally. The access delay is paid once, before the first beat. Later beats follow on consecutive cycles whenever the manager is ready to take them.

Top module: `axrd_mem`

## Requirements
- R1: A request is taken only on a rising clock edge at which ARVALID and ARREADY are both high, and each such edge starts exactly one read. A request held on ARVALID while ARREADY is low is not taken until ARREADY returns high.
- R2: ARREADY is low from the edge that takes a request until the edge at which the beat with RLAST is accepted. It is high at every other time, so at most one read is in flight.
- R3: A read with length field L returns exactly L+1 beats.
- R4: RLAST is high on the final beat of a burst and on no other beat. With L=0 the single beat already has RLAST high.
- R5: RRESP is decided for each beat. OKAY is 2'b00 and DECERR is 2'b11. A beat whose byte address is at least DEPTH*4 returns DECERR with RDATA equal to zero. Every other beat returns OKAY.
- R6: While RVALID is high and RREADY is low, RVALID, RDATA, RRESP, RLAST and RID keep their values.
- R7: RVALID first rises exactly LATENCY clock edges after the edge that took the request. After each accepted beat that is not the last, the next beat is valid in the very next cycle.
- R8: Beat b of a read starting at byte address A uses address A+4*b. An in-range beat at address a returns word k=a/4, and word k holds (k*32'h9E3779B9) XOR 32'h5A5A5A5A, truncated to 32 bits.
- R9: Every beat returns the request's ARID on RID.
- R10: After reset, ARREADY is high and RVALID is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arvalid | input | 1 | Read request valid |
| arready | output | 1 | Block can take a request |
| araddr | input | ADDR_W | Start byte address |
| arlen | input | 8 | Number of beats minus one |
| arid | input | ID_W | Transaction identifier |
| rvalid | output | 1 | Read beat valid |
| rready | input | 1 | Manager accepts the beat |
| rdata | output | DATA_W | Beat data |
| rresp | output | 2 | Beat response code |
| rlast | output | 1 | Final beat of the burst |
| rid | output | ID_W | Echoed identifier |

## Verification
The checker watches several properties on every cycle. It confirms that ARREADY and RVALID are never high together. It confirms that the beat outputs hold still under back-pressure and that RLAST lines up with the beat count. It also confirms that the first beat appears exactly LATENCY edges after the request, that accepted non-final beats are followed at once by another beat, and that a decode error always carries zero data. Some behaviour only the bench scenarios can show: the word values and per-beat addresses, the split between OKAY and DECERR inside a burst that runs past the array end, and the RID echo. The same holds for the queuing of a request presented while busy and for the total beat count per read.

// File: rtl/axrd_pkg.sv
package axrd_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STREAM
  } state_e;
endpackage

// File: rtl/axrd_rom.sv
module axrd_rom #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Fixed contents, computed at elaboration (block RAM init)
  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      mem[k] = DATA_W'((k * 32'h9E3779B9) ^ 32'h5A5A5A5A);
    end
  end

  // Registered read with enable: holds output while stalled
  always_ff @(posedge clk) begin
    if (en) q <= mem[idx];
  end
endmodule

// File: rtl/axrd_addr.sv
module axrd_addr #(
  parameter int ADDR_W = 16,
  parameter int BYTES  = 4,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OFF   = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              adv,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH * BYTES);

  logic [ADDR_W-1:0] cur;

  always_ff @(posedge clk) begin
    if (rst)        cur <= '0;
    else if (start) cur <= start_addr;
    else if (adv)   cur <= cur + ADDR_W'(BYTES);
  end

  always_comb begin
    in_range = {1'b0, cur} < LIMIT;
    idx      = IDX_W'(cur >> OFF);
  end
endmodule

// File: rtl/axrd_ctrl.sv
module axrd_ctrl
  import axrd_pkg::*;
#(
  parameter int ID_W    = 4,
  parameter int LATENCY = 3,
  localparam int CNT_W  = $clog2(LATENCY + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arvalid,
  input  logic [7:0]      arlen,
  input  logic [ID_W-1:0] arid,
  input  logic            rready,
  input  logic            in_range,
  output logic            ar_fire,
  output logic            load,
  output logic            arready,
  output logic            rvalid,
  output logic            rlast,
  output logic [ID_W-1:0] rid,
  output resp_e           rresp
);
  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       left;
  logic             r_fire;

  always_comb begin
    ar_fire = arvalid && arready;
    r_fire  = rvalid && rready;
    load    = ((state == ST_WAIT) && (cnt == '0)) ||
              ((state == ST_STREAM) && r_fire && !rlast);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      left    <= '0;
      arready <= 1'b1;
      rvalid  <= 1'b0;
      rlast   <= 1'b0;
      rid     <= '0;
      rresp   <= RESP_OKAY;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ar_fire) begin
            arready <= 1'b0;
            left    <= arlen;
            rid     <= arid;
            cnt     <= CNT_W'(LATENCY - 1);
            state   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
        end
        ST_STREAM: begin
          if (r_fire && rlast) begin
            rvalid  <= 1'b0;
            rlast   <= 1'b0;
            arready <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (load) begin
        rvalid <= 1'b1;
        rlast  <= (left == 8'd0);
        left   <= left - 8'd1;
        rresp  <= in_range ? RESP_OKAY : RESP_DECERR;
        state  <= ST_STREAM;
      end
    end
  end
endmodule

// File: rtl/axrd_mem.sv
module axrd_mem
  import axrd_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int DEPTH   = 256,
  parameter int LATENCY = 3,
  localparam int BYTES  = DATA_W / 8,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [7:0]        arlen,
  input  logic [ID_W-1:0]   arid,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rlast,
  output logic [ID_W-1:0]   rid
);
  logic              ar_fire;
  logic              load;
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rom_q;
  resp_e             resp_q;

  axrd_ctrl #(.ID_W(ID_W), .LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rst(rst), .arvalid(arvalid), .arlen(arlen), .arid(arid),
    .rready(rready), .in_range(in_range), .ar_fire(ar_fire), .load(load),
    .arready(arready), .rvalid(rvalid), .rlast(rlast), .rid(rid),
    .rresp(resp_q)
  );

  axrd_addr #(.ADDR_W(ADDR_W), .BYTES(BYTES), .DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst(rst), .start(ar_fire), .start_addr(araddr),
    .adv(load), .idx(idx), .in_range(in_range)
  );

  axrd_rom #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rom (
    .clk(clk), .en(load), .idx(idx), .q(rom_q)
  );

  always_comb begin
    rresp = resp_q;
    rdata = (resp_q == RESP_DECERR) ? '0 : rom_q;
  end
endmodule

// File: rtl/axrd_mem_chk.sv
module axrd_mem_chk #(
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int LATENCY = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              arvalid,
  input logic              arready,
  input logic [7:0]        arlen,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic              rlast,
  input logic [ID_W-1:0]   rid
);
  logic [31:0] since;
  logic [8:0]  beats;
  logic [7:0]  len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      beats <= '0;
      len_q <= '0;
    end else begin
      if (arvalid && arready) begin
        since <= 32'd1;
        beats <= '0;
        len_q <= arlen;
      end else begin
        if (rvalid)             since <= '0;
        else if (since != '0)   since <= since + 32'd1;
        if (rvalid && rready)   beats <= beats + 9'd1;
      end
    end
  end

  // R2: never ready for a request while a beat is pending
  p_single_flight_r2: assert property (@(posedge clk) disable iff (rst)
    !(arready && rvalid));

  // R2: last beat accepted reopens the address channel
  p_reopen_r2: assert property (@(posedge clk) disable iff (rst)
    (rvalid && rready && rlast) |=> (arready && !rvalid));

  // R6: outputs frozen under back-pressure
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp)
                             && $stable(rlast) && $stable(rid)));

  // R4: RLAST exactly on beat number len
  p_last_pos_r4: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (rlast == (beats == {1'b0, len_q})));

  // R7: first beat after LATENCY edges (counter is one ahead when sampled)
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |-> (since == 32'(LATENCY + 1)));

  // R7: beats stream back to back
  p_back2back_r7: assert property (@(posedge clk) disable iff (rst)
    (rvalid && rready && !rlast) |=> rvalid);

  // R5: only OKAY or DECERR, DECERR with zero data
  p_resp_code_r5: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> ((rresp == 2'b00) || (rresp == 2'b11)));
  p_decerr_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rvalid && rresp == 2'b11) |-> (rdata == '0));
endmodule

bind axrd_mem axrd_mem_chk #(.DATA_W(DATA_W), .ID_W(ID_W), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst(rst), .arvalid(arvalid), .arready(arready), .arlen(arlen),
  .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
  .rlast(rlast), .rid(rid)
);

// File: tb/axrd_mem_bench.sv
module axrd_mem_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT   = 3;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arvalid = 1'b0;
  logic        arready;
  logic [15:0] araddr = '0;
  logic [7:0]  arlen = '0;
  logic [3:0]  arid = '0;
  logic        rvalid;
  logic        rready = 1'b1;
  logic [31:0] rdata;
  logic [1:0]  rresp;
  logic        rlast;
  logic [3:0]  rid;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit stall_mode = 1'b0;
  int n_issued = 0;
  int n_taken  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axrd_mem #(.LATENCY(LAT), .DEPTH(DEPTH)) u_axrd_mem (
    .clk(clk), .rst(rst), .arvalid(arvalid), .arready(arready),
    .araddr(araddr), .arlen(arlen), .arid(arid), .rvalid(rvalid),
    .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast), .rid(rid)
  );

  typedef struct { logic [31:0] d; logic [1:0] r; logic l; } beat_t;
  beat_t q[$];
  bit    m_arready = 1'b1;
  bit    m_rvalid  = 1'b0;
  int    m_cd      = 0;
  logic [3:0] m_id = '0;
  int    m_len = 0;
  int    got   = 0;

  // previous-cycle snapshot for the hold check
  logic p_valid = 1'b0, p_ready = 1'b0, p_last = 1'b0;
  logic [31:0] p_data = '0;
  logic [1:0]  p_resp = '0;
  logic [3:0]  p_id = '0;

  function automatic logic [31:0] word_of(int k);
    return (k * 32'h9E3779B9) ^ 32'h5A5A5A5A;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Reference model: compare, then advance using inputs seen before the next edge
  always @(negedge clk) begin
    if (!rst) begin
      check(arready == m_arready, "R2 arready", 32'(arready), 32'(m_arready));
      check(rvalid == m_rvalid, "R7 rvalid timing", 32'(rvalid), 32'(m_rvalid));
      if (rvalid && m_rvalid && q.size() > 0) begin
        check(rdata == q[0].d, "R8 rdata", rdata, q[0].d);
        check(rresp == q[0].r, "R5 rresp", 32'(rresp), 32'(q[0].r));
        check(rlast == q[0].l, "R4 rlast", 32'(rlast), 32'(q[0].l));
        check(rid == m_id, "R9 rid", 32'(rid), 32'(m_id));
      end
      if (p_valid && !p_ready) begin
        check(rvalid && rdata == p_data && rresp == p_resp && rlast == p_last
              && rid == p_id, "R6 hold under stall", rdata, p_data);
      end
      p_valid = rvalid; p_ready = rready; p_data = rdata;
      p_resp = rresp; p_last = rlast; p_id = rid;

      if (arvalid && arready) n_taken++;
      if (rvalid && rready) begin
        got++;
        if (rlast) begin
          check(got == m_len + 1, "R3 beat count", 32'(got), 32'(m_len + 1));
          got = 0;
        end
      end

      if (m_arready && arvalid) begin
        m_arready = 1'b0;
        m_id  = arid;
        m_len = int'(arlen);
        m_cd  = LAT;
        q.delete();
        for (int b = 0; b <= int'(arlen); b++) begin
          beat_t e;
          int a;
          a = int'(araddr) + 4 * b;
          if (a < DEPTH * 4) begin e.d = word_of(a / 4); e.r = 2'b00; end
          else begin e.d = '0; e.r = 2'b11; end
          e.l = (b == int'(arlen));
          q.push_back(e);
        end
      end else if (m_cd > 0) begin
        m_cd--;
        if (m_cd == 0) m_rvalid = 1'b1;
      end else if (m_rvalid && rready) begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          m_rvalid  = 1'b0;
          m_arready = 1'b1;
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    rready = stall_mode ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  task automatic send_ar(logic [15:0] a, logic [7:0] l, logic [3:0] id);
    bit ok;
    @(posedge clk); #2;
    arvalid = 1'b1; araddr = a; arlen = l; arid = id;
    n_issued++;
    do begin
      @(negedge clk); ok = arready;
      @(posedge clk); #2;
    end while (!ok);
    arvalid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(m_arready && !m_rvalid && m_cd == 0 && !arvalid));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(arready == 1'b1, "R10 arready after reset", 32'(arready), 32'd1);
    check(rvalid == 1'b0, "R10 rvalid after reset", 32'(rvalid), 32'd0);

    send_ar(16'h0010, 8'd0, 4'd3);   wait_idle();  // R4 single beat
    send_ar(16'h0040, 8'd3, 4'd5);   wait_idle();  // R8 plain burst
    stall_mode = 1'b1;
    send_ar(16'h0100, 8'd7, 4'd9);   wait_idle();  // R6 back-pressure
    stall_mode = 1'b0;
    send_ar(16'd1016, 8'd3, 4'd2);   wait_idle();  // R5 crosses array end
    send_ar(16'h2000, 8'd1, 4'd15);  wait_idle();  // R5 fully outside
    send_ar(16'h0020, 8'd2, 4'd1);                 // R1 request while busy
    send_ar(16'h0080, 8'd0, 4'd6);   wait_idle();
    stall_mode = 1'b1;
    send_ar(16'h0300, 8'd15, 4'd12); wait_idle();  // R7 long burst
    stall_mode = 1'b0;
    send_ar(16'h03FC, 8'd0, 4'd7);   wait_idle();  // R5 last in-range word

    // R1: every issued request taken exactly once
    check(n_taken == n_issued, "R1 request count", 32'(n_taken), 32'(n_issued));
    finish_run();
  end
endmodule